// File: doc/BRIEF.md
# Flyback Cell Balancing Sequencer

This block sequences the two power switches of a bidirectional flyback balancer for each cell of a small series stack. Each cell has a primary switch across the cell winding and a secondary switch across the stack-side winding. The block switches them in alternating phases. Digital comparator flags tell it when a winding has reached peak current and when it has fallen to zero. Each cell is given a 2-bit direction command. The command only takes effect when an execute strobe latches the whole command word.

A discharge cycle moves energy out of the cell. It builds current in the primary winding and then lets it collapse through the secondary winding. A charge cycle runs the other way. Between any two phases there is one clock with both switches off. Each phase has an on-time limit, and a phase that runs past it stops the cell and sets a fault bit.

Two watchdog inputs control the whole block. A pause input blanks every gate at once and freezes the sequence so that it continues where it stopped. A timeout input stops all cells until the next execute strobe.

Top module: `cell_balance_seq`

## Requirements
- R1: Command field 01 (discharge) runs the primary switch until the primary peak flag, then the secondary switch until the secondary zero flag, and repeats. Flags for the other winding or the other direction are ignored.
- R2: Command field 10 (charge) runs the secondary switch until the secondary peak flag, then the primary switch until the primary zero flag, and repeats.
- R3: Within one cell, pri_en_o and sec_en_o are never high in the same cycle.
- R4: While wdt_pause_i is high, every gate enable is low in that same cycle. Sequence state and on-time counts are frozen and comparator flags are ignored. When the input is released, the cell continues in the phase where it stopped.
- R5: A cycle with wdt_timeout_i high stops every cell from the next clock. Cells stay stopped until the next exec_i. Timeout has priority over a simultaneous exec_i.
- R6: The command field for cell k is cmd_i[2k+1:2k]. Every cell sequences independently of the others.
- R7: Fields 00 and 11 make the cell idle with both switches off. A change on cmd_i does nothing until exec_i is high at a clock edge.
- R8: After an exec_i that starts a cell, and after each phase ends, the cell spends exactly one clock with both switches off before the next phase begins.
- R9: A gate enable stays high for at most MAX_ON_CYC consecutive unpaused cycles. If the expected flag has not arrived by then, both switches turn off, the cell goes idle and its fault bit is set. A flag in the last allowed cycle ends the phase normally. exec_i clears the fault bits.
- R10: status_o[k] is high while cell k is sequencing, and status_o[NUM_CELLS+k] is the fault bit of cell k. busy_o is the OR of the activity bits.
- R11: While rst_ni is low, and after it is released, all enables, status_o and busy_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 2*NUM_CELLS | Per-cell direction fields |
| exec_i | input | 1 | Execute strobe; latches cmd_i |
| wdt_pause_i | input | 1 | Pause all balancing in place |
| wdt_timeout_i | input | 1 | Watchdog expiry; stops all cells |
| pri_peak_i | input | NUM_CELLS | Primary winding peak-current flags |
| pri_zero_i | input | NUM_CELLS | Primary winding zero-current flags |
| sec_peak_i | input | NUM_CELLS | Secondary winding peak-current flags |
| sec_zero_i | input | NUM_CELLS | Secondary winding zero-current flags |
| pri_en_o | output | NUM_CELLS | Primary switch enables |
| sec_en_o | output | NUM_CELLS | Secondary switch enables |
| busy_o | output | 1 | Any cell sequencing |
| status_o | output | 2*NUM_CELLS | {fault bits, activity bits} |

## Verification
Discharge and charge runs each receive the flag of the wrong winding during a phase. This shows that each direction listens only to its own flag pair and opens its phases in the right order. A pause held across a peak flag shows the difference between freezing the sequence and restarting it. A timeout followed by idle cycles and a stray flag shows that only exec_i restarts a cell. Phases that end with no flag, and with a flag in the last allowed cycle, fix the on-time limit to the exact cycle. A mixed command word checks the field positions, with both directions running on different cells and code 11 idling a cell.

// File: rtl/cb_pkg.sv
package cb_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_DIS   = 2'b01,
    CMD_CHG   = 2'b10,
    CMD_IDLE2 = 2'b11
  } cb_cmd_e;

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_GAP = 2'd1,
    ST_PRI = 2'd2,
    ST_SEC = 2'd3
  } cb_state_e;
endpackage

// File: rtl/cb_phase_timer.sv
module cb_phase_timer #(
  parameter int MAX_ON_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int CW = (MAX_ON_CYC > 1) ? $clog2(MAX_ON_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(MAX_ON_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (en_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cb_cell_seq.sv
module cb_cell_seq
  import cb_pkg::*;
#(
  parameter int MAX_ON_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       exec_i,
  input  logic [1:0] cmd_i,
  input  logic       pause_i,
  input  logic       timeout_i,
  input  logic       pri_peak_i,
  input  logic       pri_zero_i,
  input  logic       sec_peak_i,
  input  logic       sec_zero_i,
  output logic       pri_en_o,
  output logic       sec_en_o,
  output logic       active_o,
  output logic       fault_o
);
  cb_state_e state_q, state_d;
  logic chg_q, chg_d;         // 1: charge direction
  logic nxt_pri_q, nxt_pri_d; // phase after the gap uses primary
  logic fault_q, fault_d;
  logic in_phase, end_flag, expired;

  assign in_phase = (state_q == ST_PRI) || (state_q == ST_SEC);

  always_comb begin
    end_flag = 1'b0;
    if (state_q == ST_PRI) end_flag = chg_q ? pri_zero_i : pri_peak_i;
    if (state_q == ST_SEC) end_flag = chg_q ? sec_peak_i : sec_zero_i;
  end

  cb_phase_timer #(.MAX_ON_CYC(MAX_ON_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_q == ST_GAP),
    .en_i      (in_phase && !pause_i && !end_flag),
    .expired_o (expired)
  );

  always_comb begin
    state_d   = state_q;
    chg_d     = chg_q;
    nxt_pri_d = nxt_pri_q;
    fault_d   = fault_q;
    if (timeout_i) begin
      state_d = ST_OFF;
    end else if (exec_i) begin
      fault_d = 1'b0;
      if (cmd_i == CMD_DIS || cmd_i == CMD_CHG) begin
        state_d   = ST_GAP;
        chg_d     = (cmd_i == CMD_CHG);
        nxt_pri_d = (cmd_i == CMD_DIS);
      end else begin
        state_d = ST_OFF;
      end
    end else if (!pause_i) begin
      unique case (state_q)
        ST_GAP: state_d = nxt_pri_q ? ST_PRI : ST_SEC;
        ST_PRI, ST_SEC: begin
          if (end_flag) begin
            state_d   = ST_GAP;
            nxt_pri_d = (state_q == ST_SEC);
          end else if (expired) begin
            state_d = ST_OFF;
            fault_d = 1'b1;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OFF;
      chg_q     <= 1'b0;
      nxt_pri_q <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      chg_q     <= chg_d;
      nxt_pri_q <= nxt_pri_d;
      fault_q   <= fault_d;
    end
  end

  assign pri_en_o = (state_q == ST_PRI) && !pause_i;
  assign sec_en_o = (state_q == ST_SEC) && !pause_i;
  assign active_o = (state_q != ST_OFF);
  assign fault_o  = fault_q;
endmodule

// File: rtl/cell_balance_seq.sv
module cell_balance_seq #(
  parameter int NUM_CELLS  = 6,
  parameter int MAX_ON_CYC = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2*NUM_CELLS-1:0] cmd_i,
  input  logic                   exec_i,
  input  logic                   wdt_pause_i,
  input  logic                   wdt_timeout_i,
  input  logic [NUM_CELLS-1:0]   pri_peak_i,
  input  logic [NUM_CELLS-1:0]   pri_zero_i,
  input  logic [NUM_CELLS-1:0]   sec_peak_i,
  input  logic [NUM_CELLS-1:0]   sec_zero_i,
  output logic [NUM_CELLS-1:0]   pri_en_o,
  output logic [NUM_CELLS-1:0]   sec_en_o,
  output logic                   busy_o,
  output logic [2*NUM_CELLS-1:0] status_o
);
  logic [NUM_CELLS-1:0] active, fault;

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
    cb_cell_seq #(.MAX_ON_CYC(MAX_ON_CYC)) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .exec_i     (exec_i),
      .cmd_i      (cmd_i[2*k+1:2*k]),
      .pause_i    (wdt_pause_i),
      .timeout_i  (wdt_timeout_i),
      .pri_peak_i (pri_peak_i[k]),
      .pri_zero_i (pri_zero_i[k]),
      .sec_peak_i (sec_peak_i[k]),
      .sec_zero_i (sec_zero_i[k]),
      .pri_en_o   (pri_en_o[k]),
      .sec_en_o   (sec_en_o[k]),
      .active_o   (active[k]),
      .fault_o    (fault[k])
    );
  end

  assign status_o = {fault, active};
  assign busy_o   = |active;
endmodule

// File: rtl/cb_seq_checker.sv
module cb_seq_checker #(
  parameter int NUM_CELLS = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [2*NUM_CELLS-1:0] cmd_i,
  input logic                   exec_i,
  input logic                   wdt_pause_i,
  input logic                   wdt_timeout_i,
  input logic [NUM_CELLS-1:0]   pri_en_o,
  input logic [NUM_CELLS-1:0]   sec_en_o,
  input logic                   busy_o,
  input logic [2*NUM_CELLS-1:0] status_o
);
  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_en_o & sec_en_o) == '0);

  p_pause_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_pause_i |-> (pri_en_o == '0) && (sec_en_o == '0));

  p_timeout_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_timeout_i |=> !busy_o);

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_chk
    p_gap_after_pri_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pri_en_o[k] |=> !sec_en_o[k]);
    p_gap_after_sec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sec_en_o[k] |=> !pri_en_o[k]);
    p_exec_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exec_i |=> !pri_en_o[k] && !sec_en_o[k]);
    p_idle_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exec_i && (cmd_i[2*k+1:2*k] == cmd_i[2*k+1:2*k+0] ) &&
      (cmd_i[2*k+1] == cmd_i[2*k]) |=> !status_o[k]);
    p_fault_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[NUM_CELLS+k] && !exec_i |=> status_o[NUM_CELLS+k]);
  end
endmodule

bind cell_balance_seq cb_seq_checker #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_i         (cmd_i),
  .exec_i        (exec_i),
  .wdt_pause_i   (wdt_pause_i),
  .wdt_timeout_i (wdt_timeout_i),
  .pri_en_o      (pri_en_o),
  .sec_en_o      (sec_en_o),
  .busy_o        (busy_o),
  .status_o      (status_o)
);

// File: tb/cell_balance_seq_test.sv
module cell_balance_seq_test;
  localparam int N   = 6;
  localparam int MAX = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2*N-1:0] cmd_i = '0;
  logic exec_i = 0, wdt_pause_i = 0, wdt_timeout_i = 0;
  logic [N-1:0] pri_peak_i = '0, pri_zero_i = '0, sec_peak_i = '0, sec_zero_i = '0;
  logic [N-1:0] pri_en_o, sec_en_o;
  logic busy_o;
  logic [2*N-1:0] status_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  cell_balance_seq #(.NUM_CELLS(N), .MAX_ON_CYC(MAX)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .exec_i(exec_i),
    .wdt_pause_i(wdt_pause_i), .wdt_timeout_i(wdt_timeout_i),
    .pri_peak_i(pri_peak_i), .pri_zero_i(pri_zero_i),
    .sec_peak_i(sec_peak_i), .sec_zero_i(sec_zero_i),
    .pri_en_o(pri_en_o), .sec_en_o(sec_en_o),
    .busy_o(busy_o), .status_o(status_o));

  // {exec, pause, pri_peak, pri_zero, sec_peak, sec_zero, cmd0[1:0], exp_pri, exp_sec, exp_busy}
  localparam int NV = 19;
  localparam logic [10:0] VEC [0:NV-1] = '{
    11'b1_0_0000_01_001, // R1 R8 exec discharge -> gap
    11'b0_0_0000_01_101, // R1 primary phase
    11'b0_0_0001_01_101, // R1 wrong flag ignored
    11'b0_0_1000_01_001, // R1 R8 peak -> gap
    11'b0_0_0000_01_011, // R1 secondary phase
    11'b0_0_0001_01_001, // R1 zero -> gap
    11'b0_0_0000_01_101, // R1 primary again
    11'b0_1_0000_01_001, // R4 paused, gates low
    11'b0_1_1000_01_001, // R4 flag ignored while paused
    11'b0_0_0000_01_101, // R4 resume in primary
    11'b0_0_1000_01_001, // R1 peak -> gap
    11'b1_0_0000_10_001, // R2 R8 exec charge -> gap
    11'b0_0_1000_10_011, // R2 secondary first, primary flag ignored
    11'b0_0_0010_10_001, // R2 secondary peak -> gap
    11'b0_0_0000_10_101, // R2 primary phase
    11'b0_0_0100_10_001, // R2 primary zero -> gap
    11'b0_0_0000_10_011, // R2 secondary again
    11'b0_0_0000_00_011, // R7 command change without exec ignored
    11'b1_0_0000_00_000  // R7 exec idle -> off
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_in();
    exec_i = 0; wdt_pause_i = 0; wdt_timeout_i = 0;
    pri_peak_i = '0; pri_zero_i = '0; sec_peak_i = '0; sec_zero_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    #5;
    chk(pri_en_o == 0 && sec_en_o == 0 && status_o == 0 && !busy_o, "R11 in reset",
        {pri_en_o, sec_en_o, status_o}, 0);
    repeat (2) step();
    rst_ni = 1'b1;
    step();
    chk(pri_en_o == 0 && sec_en_o == 0 && status_o == 0 && !busy_o, "R11 after reset",
        {pri_en_o, sec_en_o, status_o}, 0);

    for (int i = 0; i < NV; i++) begin
      exec_i = VEC[i][10]; wdt_pause_i = VEC[i][9];
      pri_peak_i = {5'b0, VEC[i][8]}; pri_zero_i = {5'b0, VEC[i][7]};
      sec_peak_i = {5'b0, VEC[i][6]}; sec_zero_i = {5'b0, VEC[i][5]};
      cmd_i = {10'b0, VEC[i][4:3]};
      step();
      chk({pri_en_o[0], sec_en_o[0], busy_o} == VEC[i][2:0], $sformatf("R1/R2 vec %0d", i),
          {pri_en_o[0], sec_en_o[0], busy_o}, VEC[i][2:0]);
    end
    clear_in();

    // R5 timeout stops, only exec restarts
    cmd_i = 12'b01; exec_i = 1; step(); exec_i = 0; step();
    chk(pri_en_o[0], "R5 setup primary on", pri_en_o, 1);
    wdt_timeout_i = 1; step(); wdt_timeout_i = 0;
    chk(!busy_o && pri_en_o == 0, "R5 timeout stops", busy_o, 0);
    repeat (3) step();
    pri_peak_i = 6'b1; step(); pri_peak_i = '0;
    chk(!busy_o && pri_en_o == 0 && sec_en_o == 0, "R5 stays off without exec", busy_o, 0);
    wdt_timeout_i = 1; exec_i = 1; step(); clear_in();
    chk(!busy_o, "R5 timeout beats exec", busy_o, 0);
    exec_i = 1; step(); exec_i = 0;
    chk(busy_o && pri_en_o == 0, "R5 R8 exec restarts via gap", {busy_o, pri_en_o}, 7'h40);
    step();
    chk(pri_en_o[0], "R5 primary after restart", pri_en_o, 1);

    // R9 on-time limit with no flag
    n = 1;
    for (int j = 0; j < 100 && pri_en_o[0]; j++) begin
      step();
      if (pri_en_o[0]) n++;
    end
    chk(n == MAX, "R9 on-time length", n, MAX);
    chk(status_o[N] && !busy_o && pri_en_o == 0, "R9 fault set, cell off", status_o, 12'h040);

    // R9 flag on last allowed cycle ends normally; exec clears fault
    exec_i = 1; step(); exec_i = 0;
    chk(!status_o[N], "R9 exec clears fault", status_o, 12'h001);
    step();
    for (int j = 0; j < MAX - 1; j++) step();
    chk(pri_en_o[0], "R9 still on at last cycle", pri_en_o, 1);
    pri_peak_i = 6'b1; step(); pri_peak_i = '0;
    chk(!status_o[N] && busy_o && pri_en_o == 0, "R9 R8 last-cycle flag -> gap", status_o, 12'h001);
    step();
    chk(sec_en_o[0] && !pri_en_o[0], "R1 secondary after last-cycle peak", sec_en_o, 1);

    // R6 R7 mixed field positions: cell1 discharge, cell2 charge, cell3 code 11
    cmd_i = 12'b00_00_11_10_01_00; exec_i = 1; step(); exec_i = 0;
    chk(pri_en_o == 0 && sec_en_o == 0 && status_o[N-1:0] == 6'b000110, "R6 R8 gap all cells",
        status_o, 12'h006);
    step();
    chk(pri_en_o == 6'b000010, "R6 cell1 primary", pri_en_o, 6'b000010);
    chk(sec_en_o == 6'b000100, "R6 cell2 secondary", sec_en_o, 6'b000100);
    chk(status_o == 12'h006 && busy_o, "R10 R7 status bits, code 11 idle", status_o, 12'h006);
    pri_peak_i = 6'b000100; step(); pri_peak_i = '0;
    chk(pri_en_o == 6'b000010 && sec_en_o == 6'b000100, "R6 other cell flag ignored",
        {pri_en_o, sec_en_o}, 12'h084);
    sec_peak_i = 6'b000100; step(); sec_peak_i = '0;
    chk(pri_en_o == 6'b000010 && sec_en_o == 0, "R6 cell2 ends alone", {pri_en_o, sec_en_o}, 12'h080);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule